// File: doc/BRIEF.md
# Power Domain Sequencing Controller

This block moves one switchable power domain between full-power operation and two low-power modes. It runs on an always-on clock. In the clock-gated mode only the domain clock is stopped. In the power-gated mode the domain is shut down in a fixed order: the clock stops first, then the isolation clamps close, then the power switch opens. Exit from the power-gated mode runs the reverse order. The switch closes and the controller waits for its acknowledge. The domain reset is held for a programmable time. Reset is released, then isolation, and the clock is ungated last. The steps that have no acknowledge each last a programmable number of cycles.

Software-visible mode state is kept in the always-on part of the block, in three registers: the mode the block is in now, the mode it came from, and the mode it is heading for. These registers survive every power-gated period. A request for an undefined mode code is refused. A request made while the block is not settled in a run mode is also refused.

Wakeup sources are asynchronous. Each one passes through a two-flop synchronizer and is then held as a pending level, so that a single-cycle pulse still causes a wakeup. An abort input cancels a low-power entry that is in progress. Before the power switch has opened, the controller backs out directly. Once the switch has opened, the controller runs the full exit sequence. A bank of retention-RAM supply switches follows the domain switch. Regions marked as retained stay powered, and the other regions are switched off together with the domain.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset: clk_en_o=1, iso_o=0, sw_en_o=1, dom_rst_o=0, every ram_sw_en_o bit is 1, cur/prev/tgt mode are 0 and req_reject_o=0.
- R2: Mode code 3 (power-gated) entry: clk_en_o falls first, and iso_o stays 0 for exactly step_wait_i+1 cycles. iso_o then rises and sw_en_o stays 1 for exactly step_wait_i+1 cycles before falling. At all times, clk_en_o=1 implies iso_o=0, and sw_en_o=0 implies iso_o=1.
- R3: Exit from the power-gated mode closes the switch and asserts dom_rst_o, then releases dom_rst_o, then iso_o, then raises clk_en_o. dom_rst_o=1 always implies iso_o=1 and clk_en_o=0.
- R4: dom_rst_o stays high for exactly rst_hold_i+1 cycles after the first clock edge at which sw_ack_i is sampled high during exit.
- R5: Mode code 2 (clock-gated) drops only clk_en_o. iso_o stays 0 and sw_en_o stays 1, and wakeup goes straight back to run.
- R6: Codes 0 and 1 are run modes. cur_mode_o changes when a mode is reached, and prev_mode_o then takes the old cur_mode_o. tgt_mode_o shows the destination and returns to the origin run mode on wakeup or abort.
- R7: A request with a code of 4 to 7, or any request while the block is not settled in a run mode, gives req_reject_o=1 in the next cycle and changes no mode register.
- R8: In the clock-gated mode, any pending source with wake_en_i set wakes the block. In the power-gated mode, a pending source wakes the block only if both wake_en_i and wake_pg_sel_i are set. Other sources leave the mode unchanged.
- R9: A one-cycle wake pulse is synchronized through two flops and held pending until it is used. Pending wakes are cleared when a low-power request is accepted.
- R10: An abort during the clock-gating step returns to run without ever raising iso_o. An abort during the isolation step releases iso_o and then ungates the clock. In both cases sw_en_o never falls. Abort beats step completion in the same cycle.
- R11: An abort after sw_en_o has fallen, or while in the power-gated mode, runs the full exit sequence including dom_rst_o.
- R12: While settled in the power-gated mode, ram_sw_en_o equals ram_keep_i. Otherwise every ram_sw_en_o bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Mode request strobe |
| req_mode_i | input | REQ_W | Requested mode code (0,1 run; 2 clock-gated; 3 power-gated) |
| wake_i | input | NUM_WAKE | Asynchronous wakeup sources |
| wake_en_i | input | NUM_WAKE | Sources enabled for wakeup |
| wake_pg_sel_i | input | NUM_WAKE | Sources also allowed in the power-gated mode |
| abort_i | input | 1 | Cancel a low-power entry |
| sw_ack_i | input | 1 | Domain power switch acknowledge (1 = powered) |
| step_wait_i | input | CNT_W | Length minus one of each step without acknowledge |
| rst_hold_i | input | CNT_W | Domain reset hold length minus one |
| ram_keep_i | input | NUM_RAM | RAM regions kept powered when the domain is off |
| clk_en_o | output | 1 | Domain clock enable |
| iso_o | output | 1 | Isolation clamp enable |
| sw_en_o | output | 1 | Domain power switch enable |
| dom_rst_o | output | 1 | Domain reset, active high |
| ram_sw_en_o | output | NUM_RAM | Per-region RAM supply switch enable |
| cur_mode_o | output | 2 | Current mode |
| prev_mode_o | output | 2 | Previous mode |
| tgt_mode_o | output | 2 | Target mode |
| req_reject_o | output | 1 | One-cycle pulse for a refused request |

## Verification
Two functions can act in the same cycle: an abort, and the completion of an entry step. With step_wait_i at 0, every cycle of the clock-gating step is also the cycle in which that step ends. The bench raises abort_i in exactly that cycle and expects the backout to win: iso_o must never rise and clk_en_o must come back. A second coincidence is tested as well: an abort in the cycle after sw_en_o falls, while sw_ack_i is still high. There the bench expects a full exit with dom_rst_o asserted, rather than a direct return to run.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    MODE_RUN0 = 2'd0,
    MODE_RUN1 = 2'd1,
    MODE_DOZE = 2'd2,
    MODE_OFF  = 2'd3
  } pmode_e;

  typedef enum logic [3:0] {
    S_RUN, S_E_CLK, S_E_ISO, S_E_SW, S_DOZE,
    S_OFF, S_X_SW, S_X_RST, S_X_ISO, S_X_CLK
  } seq_st_e;

  typedef struct packed {
    logic clk_en;
    logic iso;
    logic sw_en;
    logic dom_rst;
  } dom_ctl_t;
endpackage

// File: rtl/pwr_wake_latch.sv
module pwr_wake_latch #(
  parameter int unsigned NUM_WAKE = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_WAKE-1:0] wake_i,
  input  logic                clr_i,
  output logic [NUM_WAKE-1:0] pend_o
);
  for (genvar g = 0; g < NUM_WAKE; g++) begin : g_src
    logic s1_q, s2_q, pend_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q   <= 1'b0;
        s2_q   <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        s1_q   <= wake_i[g];
        s2_q   <= s1_q;
        pend_q <= clr_i ? 1'b0 : (pend_q | s2_q);
      end
    end
    assign pend_o[g] = pend_q;

    // R9: a pending wake is held until cleared
    a_r9_pend_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_o[g] && !clr_i) |=> pend_o[g]);
  end
endmodule

// File: rtl/pwr_step_timer.sv
module pwr_step_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (restart_i)      cnt_q <= '0;
    else if (cnt_q != '1)    cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q >= limit_i);
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
#(
  parameter int unsigned REQ_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [REQ_W-1:0] req_mode_i,
  input  logic             wake_doze_i,
  input  logic             wake_off_i,
  input  logic             abort_i,
  input  logic             sw_ack_i,
  input  logic             step_done_i,
  output seq_st_e          state_o,
  output logic             restart_o,
  output dom_ctl_t         ctl_o,
  output pmode_e           cur_o,
  output pmode_e           prev_o,
  output pmode_e           tgt_o,
  output logic             reject_o,
  output logic             pend_clr_o
);
  seq_st_e state_q, state_d;
  pmode_e  cur_q, prev_q, tgt_q, home_q, req_code;
  logic    reject_q, req_ok, accept, to_lp, leave_lp;

  assign req_code = pmode_e'(req_mode_i[1:0]);
  assign req_ok   = (req_mode_i[REQ_W-1:2] == '0);
  assign accept   = (state_q == S_RUN) && req_valid_i && req_ok;
  assign to_lp    = accept && req_code[1];
  assign pend_clr_o = to_lp;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_RUN:   if (to_lp) state_d = S_E_CLK;
      S_E_CLK: if (abort_i) state_d = S_RUN;
               else if (step_done_i) state_d = (tgt_q == MODE_DOZE) ? S_DOZE : S_E_ISO;
      S_E_ISO: if (abort_i) state_d = S_X_CLK;
               else if (step_done_i) state_d = S_E_SW;
      S_E_SW:  if (abort_i) state_d = S_X_SW;
               else if (!sw_ack_i) state_d = S_OFF;
      S_DOZE:  if (wake_doze_i || abort_i) state_d = S_RUN;
      S_OFF:   if (wake_off_i || abort_i) state_d = S_X_SW;
      S_X_SW:  if (sw_ack_i) state_d = S_X_RST;
      S_X_RST: if (step_done_i) state_d = S_X_ISO;
      S_X_ISO: if (step_done_i) state_d = S_X_CLK;
      S_X_CLK: if (step_done_i) state_d = S_RUN;
      default: state_d = S_RUN;
    endcase
  end

  assign restart_o = (state_d != state_q);
  assign leave_lp  = (state_q inside {S_E_CLK, S_E_ISO, S_E_SW, S_DOZE, S_OFF}) &&
                     (state_d inside {S_RUN, S_X_SW, S_X_CLK});

  always_comb begin
    ctl_o = '{clk_en: 1'b1, iso: 1'b0, sw_en: 1'b1, dom_rst: 1'b0};
    unique case (state_q)
      S_E_CLK, S_DOZE, S_X_CLK: ctl_o.clk_en = 1'b0;
      S_E_ISO, S_X_ISO: begin
        ctl_o.clk_en = 1'b0;
        ctl_o.iso    = 1'b1;
      end
      S_E_SW, S_OFF: begin
        ctl_o.clk_en = 1'b0;
        ctl_o.iso    = 1'b1;
        ctl_o.sw_en  = 1'b0;
      end
      S_X_SW, S_X_RST: begin
        ctl_o.clk_en  = 1'b0;
        ctl_o.iso     = 1'b1;
        ctl_o.dom_rst = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_RUN;
      cur_q    <= MODE_RUN0;
      prev_q   <= MODE_RUN0;
      tgt_q    <= MODE_RUN0;
      home_q   <= MODE_RUN0;
      reject_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      reject_q <= req_valid_i && !accept;
      if (accept) begin
        tgt_q <= req_code;
        if (!req_code[1]) begin
          prev_q <= cur_q;
          cur_q  <= req_code;
          home_q <= req_code;
        end else begin
          home_q <= cur_q;
        end
      end
      if ((state_q == S_E_CLK && state_d == S_DOZE) ||
          (state_q == S_E_SW && state_d == S_OFF)) begin
        prev_q <= cur_q;
        cur_q  <= tgt_q;
      end
      if (leave_lp) tgt_q <= home_q;
      if (state_d == S_RUN && state_q != S_RUN && cur_q[1]) begin
        prev_q <= cur_q;
        cur_q  <= home_q;
      end
    end
  end

  assign state_o  = state_q;
  assign cur_o    = cur_q;
  assign prev_o   = prev_q;
  assign tgt_o    = tgt_q;
  assign reject_o = reject_q;

  // R10: early abort restores the clock at once
  a_r10_abort_early: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_E_CLK && abort_i) |=> (ctl_o.clk_en && !ctl_o.iso));
  // R11: abort once the switch is open runs the reset path
  a_r11_abort_late: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_E_SW && abort_i) |=> ctl_o.dom_rst);
  // R7: refused requests keep the current mode
  a_r7_reject_keeps_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_ok && state_q == S_RUN) |=> (reject_o && $stable(cur_q)));
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int unsigned NUM_WAKE = 4,
  parameter int unsigned NUM_RAM  = 4,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned REQ_W    = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [REQ_W-1:0]    req_mode_i,
  input  logic [NUM_WAKE-1:0] wake_i,
  input  logic [NUM_WAKE-1:0] wake_en_i,
  input  logic [NUM_WAKE-1:0] wake_pg_sel_i,
  input  logic                abort_i,
  input  logic                sw_ack_i,
  input  logic [CNT_W-1:0]    step_wait_i,
  input  logic [CNT_W-1:0]    rst_hold_i,
  input  logic [NUM_RAM-1:0]  ram_keep_i,
  output logic                clk_en_o,
  output logic                iso_o,
  output logic                sw_en_o,
  output logic                dom_rst_o,
  output logic [NUM_RAM-1:0]  ram_sw_en_o,
  output logic [1:0]          cur_mode_o,
  output logic [1:0]          prev_mode_o,
  output logic [1:0]          tgt_mode_o,
  output logic                req_reject_o
);
  seq_st_e             state;
  dom_ctl_t            ctl;
  pmode_e              cur_m, prev_m, tgt_m;
  logic [NUM_WAKE-1:0] pend;
  logic [CNT_W-1:0]    limit;
  logic                restart, step_done, pend_clr, wake_doze, wake_off;

  pwr_wake_latch #(.NUM_WAKE(NUM_WAKE)) i_wake (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wake_i (wake_i),
    .clr_i  (pend_clr),
    .pend_o (pend)
  );

  assign wake_doze = |(pend & wake_en_i);
  assign wake_off  = |(pend & wake_en_i & wake_pg_sel_i);
  assign limit     = (state == S_X_RST) ? rst_hold_i : step_wait_i;

  pwr_step_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .limit_i   (limit),
    .done_o    (step_done)
  );

  pwr_seq_fsm #(.REQ_W(REQ_W)) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_mode_i  (req_mode_i),
    .wake_doze_i (wake_doze),
    .wake_off_i  (wake_off),
    .abort_i     (abort_i),
    .sw_ack_i    (sw_ack_i),
    .step_done_i (step_done),
    .state_o     (state),
    .restart_o   (restart),
    .ctl_o       (ctl),
    .cur_o       (cur_m),
    .prev_o      (prev_m),
    .tgt_o       (tgt_m),
    .reject_o    (req_reject_o),
    .pend_clr_o  (pend_clr)
  );

  assign clk_en_o  = ctl.clk_en;
  assign iso_o     = ctl.iso;
  assign sw_en_o   = ctl.sw_en;
  assign dom_rst_o = ctl.dom_rst;

  // non-retained regions follow the domain switch
  for (genvar r = 0; r < NUM_RAM; r++) begin : g_ram
    assign ram_sw_en_o[r] = ctl.sw_en | ram_keep_i[r];
  end

  assign cur_mode_o  = cur_m;
  assign prev_mode_o = prev_m;
  assign tgt_mode_o  = tgt_m;

  // reset-hold observer for the R4 check
  logic [CNT_W:0] rst_ack_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                rst_ack_cnt_q <= '0;
    else if (!dom_rst_o)                        rst_ack_cnt_q <= '0;
    else if (sw_ack_i && rst_ack_cnt_q != '1)   rst_ack_cnt_q <= rst_ack_cnt_q + 1'b1;
  end

  a_r2_gate_before_iso: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_o |-> !iso_o);
  a_r2_iso_before_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_en_o |-> iso_o);
  a_r3_rst_under_iso: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dom_rst_o |-> (iso_o && !clk_en_o));
  a_r4_rst_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dom_rst_o) |-> (rst_ack_cnt_q > {1'b0, rst_hold_i}));
  a_r6_off_mode_switch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_mode_o == MODE_OFF && tgt_mode_o == MODE_OFF) |-> !sw_en_o);
  a_r12_ram_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_mode_o == MODE_OFF && tgt_mode_o == MODE_OFF) |-> ((ram_sw_en_o & ~ram_keep_i) == '0));
endmodule

// File: tb/test_pwr_seq_ctrl.sv
module test_pwr_seq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_mode = '0;
  logic [3:0] wake = '0, wake_en = '0, pg_sel = '0, ram_keep = '0;
  logic       abort = 1'b0;
  logic       sw_ack;
  logic [7:0] step_wait = '0, rst_hold = '0;
  logic       clk_en, iso, sw_en, dom_rst, reject;
  logic [3:0] ram_sw;
  logic [1:0] cur_m, prev_m, tgt_m;

  int n_chk = 0, n_fail = 0;
  int inv_err = 0;
  int ack_lat = 1;
  logic [7:0] ack_sh;

  always #(CLK_PERIOD/2) clk = ~clk;

  // switch model: acknowledge follows the enable after ack_lat edges
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ack_sh <= '1;
    else        ack_sh <= {ack_sh[6:0], sw_en};
  assign sw_ack = ack_sh[ack_lat-1];

  pwr_seq_ctrl i_pwr_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_mode_i(req_mode),
    .wake_i(wake), .wake_en_i(wake_en), .wake_pg_sel_i(pg_sel), .abort_i(abort),
    .sw_ack_i(sw_ack), .step_wait_i(step_wait), .rst_hold_i(rst_hold),
    .ram_keep_i(ram_keep), .clk_en_o(clk_en), .iso_o(iso), .sw_en_o(sw_en),
    .dom_rst_o(dom_rst), .ram_sw_en_o(ram_sw), .cur_mode_o(cur_m),
    .prev_mode_o(prev_m), .tgt_mode_o(tgt_m), .req_reject_o(reject)
  );

  // ordering invariants, R2 and R3
  always @(negedge clk) if (rst_n) begin
    if (clk_en && (iso || !sw_en || dom_rst)) inv_err++;
    if (!sw_en && !iso) inv_err++;
    if (dom_rst && (!iso || clk_en)) inv_err++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_req(input int m);
    req_mode = m[2:0];
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pulse_wake(input int idx);
    wake[idx] = 1'b1;
    @(negedge clk);
    wake = '0;
  endtask

  task automatic pulse_abort();
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
  endtask

  task automatic wait_cur(input int m, input int max, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < max; i++) begin
      if (int'(cur_m) == m) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  // counts entry phases for R2
  task automatic enter_off(output int ng, output int ni);
    ng = 0; ni = 0;
    send_req(3);
    for (int i = 0; i < 100; i++) begin
      if (!sw_en) break;
      if (!clk_en && !iso) ng++;
      else if (iso) ni++;
      @(negedge clk);
    end
  endtask

  // counts reset cycles with acknowledge high for R4
  task automatic count_exit(output int nr);
    nr = 0;
    for (int i = 0; i < 300; i++) begin
      if (clk_en) break;
      if (dom_rst && sw_ack) nr++;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
    $finish;
  end

  initial begin : main
    bit ok, seen;
    int ng, ni, nr, w, h, keep, home;
    void'($urandom(32'h5eed_1234));
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk(clk_en && !iso && sw_en && !dom_rst, "R1 ctl", {clk_en, iso, sw_en, dom_rst}, 4'b1010);
    chk(ram_sw == 4'hF, "R1 ram", ram_sw, 15);
    chk(cur_m == 0 && prev_m == 0 && tgt_m == 0 && !reject, "R1 modes", cur_m, 0);

    // R7 invalid code
    send_req(5);
    chk(reject == 1'b1, "R7 reject pulse", reject, 1);
    chk(cur_m == 0 && tgt_m == 0, "R7 mode kept", cur_m, 0);
    // R6 run-to-run
    send_req(1);
    chk(cur_m == 1 && prev_m == 0 && tgt_m == 1, "R6 run change", cur_m, 1);

    // R5 clock-gated mode
    wake_en = 4'b0011; pg_sel = 4'b0001; step_wait = 8'd1;
    send_req(2);
    chk(tgt_m == 2, "R6 target during entry", tgt_m, 2);
    wait_cur(2, 50, ok);
    chk(ok, "R5 doze reached", cur_m, 2);
    chk(!clk_en && !iso && sw_en && !dom_rst, "R5 only clock gated", {clk_en, iso, sw_en}, 3'b001);
    chk(prev_m == 1, "R6 prev in doze", prev_m, 1);
    send_req(0);
    chk(reject == 1'b1 && cur_m == 2, "R7 request outside run", reject, 1);
    pulse_wake(2);
    step(12);
    chk(cur_m == 2, "R8 disabled source ignored in doze", cur_m, 2);
    pulse_wake(1);
    wait_cur(1, 30, ok);
    chk(ok && prev_m == 2 && clk_en, "R8 doze wake by enabled source", cur_m, 1);

    // R9 stale pending cleared by acceptance
    pulse_wake(0);
    step(6);
    send_req(2);
    wait_cur(2, 50, ok);
    step(15);
    chk(cur_m == 2, "R9 stale wake cleared", cur_m, 2);
    pulse_wake(0);
    wait_cur(1, 30, ok);
    chk(ok, "R9 single pulse wakes", cur_m, 1);

    // R10 abort coinciding with step end (step_wait 0)
    step_wait = 8'd0;
    send_req(3);
    abort = 1'b1;
    seen = 1'b0;
    @(negedge clk);
    abort = 1'b0;
    for (int i = 0; i < 10; i++) begin seen |= iso; @(negedge clk); end
    chk(!seen && clk_en && cur_m == 1 && tgt_m == 1, "R10 abort at step end", seen, 0);

    // R10 abort in clock-gating step
    step_wait = 8'd3;
    send_req(3);
    pulse_abort();
    seen = 1'b0;
    for (int i = 0; i < 10; i++) begin seen |= iso; @(negedge clk); end
    chk(!seen && clk_en && cur_m == 1, "R10 abort in gate step", seen, 0);

    // R10 abort in isolation step
    send_req(3);
    for (int i = 0; i < 50 && !iso; i++) @(negedge clk);
    pulse_abort();
    seen = 1'b0;
    for (int i = 0; i < 15; i++) begin seen |= !sw_en; @(negedge clk); end
    chk(!seen && clk_en && !iso && tgt_m == 1, "R10 abort in iso step", seen, 0);

    // R11 abort right after switch opens
    ack_lat = 3;
    send_req(3);
    for (int i = 0; i < 50 && sw_en; i++) @(negedge clk);
    pulse_abort();
    seen = 1'b0;
    for (int i = 0; i < 100 && !clk_en; i++) begin seen |= dom_rst; @(negedge clk); end
    chk(seen && clk_en && cur_m == 1, "R11 abort after switch open", seen, 1);

    // R11 abort while power gated
    step_wait = 8'd0; ack_lat = 1;
    enter_off(ng, ni);
    wait_cur(3, 50, ok);
    pulse_abort();
    seen = 1'b0;
    for (int i = 0; i < 100 && !clk_en; i++) begin seen |= dom_rst; @(negedge clk); end
    chk(seen && cur_m == 1 && prev_m == 3, "R11 abort in off mode", cur_m, 1);

    // R8 power-gated source selection
    enter_off(ng, ni);
    wait_cur(3, 50, ok);
    pulse_wake(1);
    step(15);
    chk(cur_m == 3 && !sw_en, "R8 unselected source ignored in off", cur_m, 3);
    pulse_wake(0);
    wait_cur(1, 100, ok);
    chk(ok, "R8 selected source wakes off", cur_m, 1);

    // randomized full cycles: R2 R4 R6 R12
    for (int it = 0; it < 16; it++) begin
      w = $urandom % 4; h = $urandom % 6; keep = $urandom % 16; home = $urandom % 2;
      step_wait = w[7:0]; rst_hold = h[7:0]; ram_keep = keep[3:0];
      ack_lat = 1 + ($urandom % 4);
      step(2);
      send_req(home);
      chk(int'(cur_m) == home, "R6 home run mode", cur_m, home);
      enter_off(ng, ni);
      chk(ng == w + 1, "R2 gate step length", ng, w + 1);
      chk(ni == w + 1, "R2 iso step length", ni, w + 1);
      wait_cur(3, 50, ok);
      chk(ok && int'(prev_m) == home, "R6 off reached", prev_m, home);
      chk(ram_sw == keep[3:0], "R12 retained regions", ram_sw, keep);
      pulse_wake(0);
      count_exit(nr);
      // sample before the acknowledge edge plus rst_hold+1 after it
      chk(nr == h + 2, "R4 reset hold", nr, h + 2);
      wait_cur(home, 50, ok);
      chk(ok && prev_m == 3 && int'(tgt_m) == home, "R3 R6 exit complete", cur_m, home);
      chk(ram_sw == 4'hF, "R12 all on in run", ram_sw, 15);
    end

    chk(inv_err == 0, "R2 R3 ordering invariants", inv_err, 0);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule